// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator Register File

This block gathers a set of pending interrupt lines, supplied already qualified by a separate trigger stage, into a three-level summary tree. Eight lines form a block, eight blocks form a master, and a root byte flags each master that holds a pending block. A single active-high summary interrupt goes to the host. The host walks down the tree through a byte-wide register bus. It reads the root byte, then the status byte of the master it found, then selects a block and reads that block's pending byte. Raw line levels and per-line trigger configuration are also reached through the same block-select pointer and shared window offsets.

Configuration written through the window is held here, one 3-bit setting per line, and is driven out to the trigger stage. A configuration write can also request a one-cycle clear pulse on the addressed line. The line count is a parameter of up to 256. The block count is the line count divided by 8, rounded up, and the master count is the block count divided by 8, rounded up. Lines and blocks beyond those counts read as zero.

The request channel is valid/ready. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. A read returns its byte on the response channel in the next cycle. The response stays valid and stable until it is taken by `rsp_ready_i`. While a response is waiting and `rsp_ready_i` is low, `req_ready_o` is low, which stalls the request side. Writes produce no response.

Top module: `irq_agg_top`

## Requirements
- R1: Offset 0 reads the root byte. Bit 0 of the root byte is always 0, and bit m+1 is 1 exactly when master m has at least one pending line.
- R2: Offsets 1 to 4 read the status bytes of masters 0 to 3. Bit i of master m's byte is the OR of the 8 pending lines of block m*8+i. A master at or beyond the master count reads 0.
- R3: Offset 6 reads the pending byte of the block held in the select register. Bit i of that byte is line sel*8+i. A select value at or beyond the block count, or a line at or beyond the line count, reads 0.
- R4: Offset 8 reads the raw levels of the selected block's 8 lines, whatever their pending state.
- R5: Offset 5 is the block-select register. Writes load it, and reads return the last value written. It resets to 0.
- R6: `irq_o` is 1 exactly while any pending line is 1, with no clock delay.
- R7: A write to offset 7 latches data[6:4] as the line index. It stores data[2:0] as the setting of line sel*8+index, if that line exists. In the setting, bit 0 selects level mode, bit 1 masks falling edges and bit 2 masks rising edges. A line's setting appears on `line_cfg_o[3*l +: 3]` from the cycle after the write. Reading offset 7 returns {0, index, 0, setting of line sel*8+index}.
- R8: When a write to offset 7 has data[3] set, the addressed line, and only that line, gets a `line_clr_o` pulse. The pulse lasts exactly one cycle and comes in the cycle after the write is accepted. Data[3] is never stored.
- R9: Offsets 9 to 15 read 0. Writes to any offset other than 5 and 7 change no state.
- R10: A read accepted on one edge gives `rsp_valid_o` high after that edge. Data and valid stay unchanged while `rsp_ready_i` is low, and `req_ready_o` is low in that time. Writes never raise `rsp_valid_o`.
- R11: After reset the select register is 0, the latched index is 0, every line setting is 3'b110, `rsp_valid_o` is 0 and no clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pend_i | input | NUM_LINES | Qualified pending flag per line |
| line_raw_i | input | NUM_LINES | Raw level per line |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register offset |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response taken |
| rsp_rdata_o | output | 8 | Read response data |
| irq_o | output | 1 | Summary interrupt, active high |
| line_cfg_o | output | 3*NUM_LINES | Per-line trigger setting |
| line_clr_o | output | NUM_LINES | Per-line one-cycle clear pulse |

## Verification
On every cycle, the assertions check the response handshake: a read is followed by a response, the response holds while stalled, writes produce no response, and the request side is blocked during a stall. They also check that the summary output follows the pending lines, that at most one clear pulse is active, and that each pulse follows a clearing config write. The offset map, the root, master and block bit positions, the partial last block and the missing masters can only be shown by the bench's scenarios. The same holds for the raw window, config storage and readback, and the writes that must be ignored.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [3:0] {
    OFF_ROOT = 4'd0,
    OFF_MST0 = 4'd1,
    OFF_SEL  = 4'd5,
    OFF_STAT = 4'd6,
    OFF_CFG  = 4'd7,
    OFF_RAW  = 4'd8
  } reg_off_e;

  localparam int LINES_PER_BLK = 8;
  localparam int BLKS_PER_MST  = 8;
  localparam int MAX_MASTERS   = 4;

  typedef struct packed {
    logic mask_rise;
    logic mask_fall;
    logic level;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{mask_rise: 1'b1, mask_fall: 1'b1, level: 1'b0};
endpackage

// File: rtl/irq_agg_tree.sv
module irq_agg_tree #(
  parameter int NUM_LINES   = 256,
  parameter int NUM_BLOCKS  = 32,
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_LINES-1:0]       pend_i,
  input  logic [NUM_LINES-1:0]       raw_i,
  output logic [NUM_BLOCKS*8-1:0]    pend_pad_o,
  output logic [NUM_BLOCKS*8-1:0]    raw_pad_o,
  output logic [NUM_MASTERS*8-1:0]   mst_bytes_o,
  output logic [7:0]                 root_o,
  output logic                       any_o
);
  localparam int PAD_LINES = NUM_BLOCKS * 8;
  localparam int PAD_BLKS  = NUM_MASTERS * 8;

  logic [NUM_BLOCKS-1:0] blk_any;

  for (genvar l = 0; l < PAD_LINES; l++) begin : g_line
    if (l < NUM_LINES) begin : g_real
      assign pend_pad_o[l] = pend_i[l];
      assign raw_pad_o[l]  = raw_i[l];
    end else begin : g_pad
      assign pend_pad_o[l] = 1'b0;
      assign raw_pad_o[l]  = 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blk_any[b] = |pend_pad_o[b*8 +: 8];
  end

  for (genvar g = 0; g < PAD_BLKS; g++) begin : g_mbit
    if (g < NUM_BLOCKS) begin : g_real
      assign mst_bytes_o[g] = blk_any[g];
    end else begin : g_pad
      assign mst_bytes_o[g] = 1'b0;
    end
  end

  for (genvar r = 0; r < 8; r++) begin : g_root
    if (r >= 1 && r <= NUM_MASTERS) begin : g_mst
      assign root_o[r] = |mst_bytes_o[(r-1)*8 +: 8];
    end else begin : g_zero
      assign root_o[r] = 1'b0;
    end
  end

  assign any_o = |root_o;
endmodule

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             sel_i,
  input  logic                   we_i,
  input  logic [6:0]             wdata_i,
  output logic [NUM_LINES*3-1:0] cfg_o,
  output logic [NUM_LINES-1:0]   clr_o,
  output logic [7:0]             rd_o
);
  logic [2:0]           idx_q;
  line_cfg_t            cfg_q [NUM_LINES];
  logic [NUM_LINES-1:0] clr_q;
  logic [10:0]          tgt_line;
  logic [10:0]          rd_line;
  line_cfg_t            rd_cfg;

  assign tgt_line = {sel_i, wdata_i[6:4]};
  assign rd_line  = {sel_i, idx_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 3'd0;
      clr_q <= '0;
      for (int l = 0; l < NUM_LINES; l++) cfg_q[l] <= CFG_RESET;
    end else begin
      clr_q <= '0;
      if (we_i) begin
        idx_q <= wdata_i[6:4];
        for (int l = 0; l < NUM_LINES; l++) begin
          if (tgt_line == 11'(l)) begin
            cfg_q[l] <= line_cfg_t'(wdata_i[2:0]);
            clr_q[l] <= wdata_i[3];
          end
        end
      end
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (rd_line == 11'(l)) rd_cfg = cfg_q[l];
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_out
    assign cfg_o[l*3 +: 3] = cfg_q[l];
  end

  assign clr_o = clr_q;
  assign rd_o  = {1'b0, idx_q, 1'b0, rd_cfg};
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int NUM_BLOCKS  = 32,
  parameter int NUM_MASTERS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic [3:0]               req_addr_i,
  input  logic [7:0]               req_wdata_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [7:0]               rsp_rdata_o,
  input  logic [7:0]               root_i,
  input  logic [NUM_MASTERS*8-1:0] mst_bytes_i,
  input  logic [NUM_BLOCKS*8-1:0]  pend_pad_i,
  input  logic [NUM_BLOCKS*8-1:0]  raw_pad_i,
  input  logic [7:0]               cfg_rd_i,
  output logic [7:0]               sel_o,
  output logic                     cfg_we_o,
  output logic [6:0]               cfg_wdata_o
);
  logic       rsp_q;
  logic [7:0] rdata_q;
  logic [7:0] sel_q;
  logic       acc;
  logic [7:0] win_pend;
  logic [7:0] win_raw;
  logic [7:0] mst_rd;
  logic [7:0] rd_mux;

  assign req_ready_o = !rsp_q || rsp_ready_i;
  assign acc         = req_valid_i && req_ready_o;

  always_comb begin
    win_pend = '0;
    win_raw  = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (sel_q == 8'(b)) begin
        win_pend = pend_pad_i[b*8 +: 8];
        win_raw  = raw_pad_i[b*8 +: 8];
      end
    end
  end

  always_comb begin
    mst_rd = '0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (req_addr_i == 4'(int'(OFF_MST0) + m)) mst_rd = mst_bytes_i[m*8 +: 8];
  end

  always_comb begin
    unique case (req_addr_i)
      OFF_ROOT:                     rd_mux = root_i;
      4'd1, 4'd2, 4'd3, 4'd4:       rd_mux = mst_rd;
      OFF_SEL:                      rd_mux = sel_q;
      OFF_STAT:                     rd_mux = win_pend;
      OFF_CFG:                      rd_mux = cfg_rd_i;
      OFF_RAW:                      rd_mux = win_raw;
      default:                      rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      rdata_q <= 8'h00;
      sel_q   <= 8'h00;
    end else begin
      if (acc && !req_write_i) begin
        rsp_q   <= 1'b1;
        rdata_q <= rd_mux;
      end else if (rsp_ready_i) begin
        rsp_q <= 1'b0;
      end
      if (acc && req_write_i && req_addr_i == OFF_SEL) sel_q <= req_wdata_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign sel_o       = sel_q;
  assign cfg_we_o    = acc && req_write_i && req_addr_i == OFF_CFG;
  assign cfg_wdata_o = req_wdata_i[6:0];
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   line_pend_i,
  input  logic [NUM_LINES-1:0]   line_raw_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [3:0]             req_addr_i,
  input  logic [7:0]             req_wdata_i,
  output logic                   rsp_valid_o,
  input  logic                   rsp_ready_i,
  output logic [7:0]             rsp_rdata_o,
  output logic                   irq_o,
  output logic [NUM_LINES*3-1:0] line_cfg_o,
  output logic [NUM_LINES-1:0]   line_clr_o
);
  localparam int NUM_BLOCKS  = (NUM_LINES + LINES_PER_BLK - 1) / LINES_PER_BLK;
  localparam int NUM_MASTERS = (NUM_BLOCKS + BLKS_PER_MST - 1) / BLKS_PER_MST;

  initial begin
    if (NUM_LINES < 1 || NUM_MASTERS > MAX_MASTERS)
      $error("irq_agg_top: NUM_LINES must be 1..256");
  end

  logic [NUM_BLOCKS*8-1:0]  pend_pad;
  logic [NUM_BLOCKS*8-1:0]  raw_pad;
  logic [NUM_MASTERS*8-1:0] mst_bytes;
  logic [7:0]               root;
  logic [7:0]               sel;
  logic                     cfg_we;
  logic [6:0]               cfg_wdata;
  logic [7:0]               cfg_rd;

  irq_agg_tree #(
    .NUM_LINES  (NUM_LINES),
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_MASTERS(NUM_MASTERS)
  ) u_tree (
    .pend_i     (line_pend_i),
    .raw_i      (line_raw_i),
    .pend_pad_o (pend_pad),
    .raw_pad_o  (raw_pad),
    .mst_bytes_o(mst_bytes),
    .root_o     (root),
    .any_o      (irq_o)
  );

  irq_agg_cfg #(
    .NUM_LINES(NUM_LINES)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel),
    .we_i   (cfg_we),
    .wdata_i(cfg_wdata),
    .cfg_o  (line_cfg_o),
    .clr_o  (line_clr_o),
    .rd_o   (cfg_rd)
  );

  irq_agg_regif #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_MASTERS(NUM_MASTERS)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i),
    .rsp_rdata_o(rsp_rdata_o),
    .root_i     (root),
    .mst_bytes_i(mst_bytes),
    .pend_pad_i (pend_pad),
    .raw_pad_i  (raw_pad),
    .cfg_rd_i   (cfg_rd),
    .sel_o      (sel),
    .cfg_we_o   (cfg_we),
    .cfg_wdata_o(cfg_wdata)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_LINES = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] line_pend_i,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 req_write_i,
  input logic [3:0]           req_addr_i,
  input logic [7:0]           req_wdata_i,
  input logic                 rsp_valid_o,
  input logic                 rsp_ready_i,
  input logic [7:0]           rsp_rdata_o,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] line_clr_o
);
  logic acc_rd, acc_wr, acc_clr;
  assign acc_rd  = req_valid_i && req_ready_o && !req_write_i;
  assign acc_wr  = req_valid_i && req_ready_o && req_write_i;
  assign acc_clr = acc_wr && req_addr_i == 4'd7 && req_wdata_i[3];

  // R10
  read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid_o);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R10
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);

  // R10
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !rsp_valid_o) |=> !rsp_valid_o);

  // R6
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|line_pend_i));

  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_clr_o));

  // R8
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_clr_o) |-> $past(acc_clr));
endmodule

bind irq_agg_top irq_agg_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_pend_i(line_pend_i),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_rdata_o(rsp_rdata_o),
  .irq_o      (irq_o),
  .line_clr_o (line_clr_o)
);

// File: tb/irq_agg_top_tb.sv
`timescale 1ns/1ps
module irq_agg_top_tb;
  localparam int NL = 76;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   line_pend = '0;
  logic [NL-1:0]   line_raw = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [3:0]      req_addr = '0;
  logic [7:0]      req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [7:0]      rsp_rdata;
  logic            irq;
  logic [NL*3-1:0] line_cfg;
  logic [NL-1:0]   line_clr;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [NL-1:0] clr_seen;

  always #4 clk = ~clk;

  irq_agg_top #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_pend_i(line_pend), .line_raw_i(line_raw),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .irq_o(irq),
    .line_cfg_o(line_cfg), .line_clr_o(line_clr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    clr_seen = line_clr;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 8'hxx;
  endtask

  function automatic logic [2:0] cfg_of(int l);
    return line_cfg[l*3 +: 3];
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R11 rsp_valid after reset", 32'(rsp_valid), 0);
    check("R11 no clear pulse", 32'(line_clr != 0), 0);
    check("R6 irq idle", 32'(irq), 0);
    check("R11 all cfg 110", 32'(line_cfg == {NL{3'b110}}), 1);
    bus_read(4'd5, d); check("R11 R5 select reset", 32'(d), 32'h00);
    bus_read(4'd7, d); check("R11 R7 cfg readback reset", 32'(d), 32'h06);
  endtask

  task automatic t_tree();
    logic [7:0] d;
    line_pend = '0; line_pend[0] = 1'b1;
    @(negedge clk);
    check("R6 irq with line 0", 32'(irq), 1);
    bus_read(4'd0, d); check("R1 root line 0", 32'(d), 32'h02);
    bus_read(4'd1, d); check("R2 master0 line 0", 32'(d), 32'h01);
    line_pend[75] = 1'b1;
    bus_read(4'd0, d); check("R1 root lines 0,75", 32'(d), 32'h06);
    bus_read(4'd2, d); check("R2 master1 block9", 32'(d), 32'h02);
    bus_read(4'd3, d); check("R2 master2 absent", 32'(d), 32'h00);
    bus_read(4'd4, d); check("R2 master3 absent", 32'(d), 32'h00);
    line_pend = '0; line_pend[19] = 1'b1;
    bus_read(4'd0, d); check("R1 root line 19", 32'(d), 32'h02);
    bus_read(4'd1, d); check("R2 master0 block2", 32'(d), 32'h04);
    line_pend = '0;
    @(negedge clk);
    check("R6 irq cleared", 32'(irq), 0);
    bus_read(4'd0, d); check("R1 root idle", 32'(d), 32'h00);
  endtask

  task automatic t_block();
    logic [7:0] d;
    line_pend = '0; line_pend[75] = 1'b1; line_pend[72] = 1'b1; line_pend[0] = 1'b1;
    bus_write(4'd5, 8'd9);
    bus_read(4'd6, d); check("R3 block9 status", 32'(d), 32'h09);
    bus_write(4'd5, 8'd0);
    bus_read(4'd6, d); check("R3 block0 status", 32'(d), 32'h01);
    bus_write(4'd5, 8'd10);
    bus_read(4'd6, d); check("R3 block out of range", 32'(d), 32'h00);
    line_pend = '0;
  endtask

  task automatic t_raw();
    logic [7:0] d;
    line_pend = '0; line_raw = '0; line_raw[75:72] = 4'hF; line_raw[70] = 1'b1;
    bus_write(4'd5, 8'd9);
    bus_read(4'd8, d); check("R4 raw block9", 32'(d), 32'h0F);
    bus_read(4'd6, d); check("R4 status stays 0", 32'(d), 32'h00);
    bus_write(4'd5, 8'd8);
    bus_read(4'd8, d); check("R4 raw block8", 32'(d), 32'h40);
    line_raw = '0;
  endtask

  task automatic t_sel();
    logic [7:0] d;
    bus_write(4'd5, 8'h23);
    bus_read(4'd5, d); check("R5 select readback", 32'(d), 32'h23);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    logic [NL*3-1:0] snap;
    bus_write(4'd5, 8'd2);
    bus_write(4'd7, 8'h51);
    check("R7 line21 cfg", 32'(cfg_of(21)), 32'h1);
    check("R7 line20 untouched", 32'(cfg_of(20)), 32'h6);
    check("R8 no clear without bit3", 32'(clr_seen != 0), 0);
    bus_read(4'd7, d); check("R7 cfg readback", 32'(d), 32'h51);
    snap = line_cfg;
    bus_write(4'd5, 8'd10);
    bus_write(4'd7, 8'h13);
    check("R7 out-of-range write ignored", 32'(line_cfg == snap), 1);
    bus_write(4'd5, 8'd9);
    bus_write(4'd7, 8'h70);
    check("R7 missing line 79 ignored", 32'(line_cfg == snap), 1);
  endtask

  task automatic t_clr();
    logic [7:0] d;
    logic [NL-1:0] exp;
    exp = '0; exp[21] = 1'b1;
    bus_write(4'd5, 8'd2);
    bus_write(4'd7, 8'h5D);
    check("R8 clear pulse line21", 32'(clr_seen == exp), 1);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(line_clr != 0), 0);
    check("R8 R7 line21 cfg 101", 32'(cfg_of(21)), 32'h5);
    bus_read(4'd7, d); check("R8 bit3 not stored", 32'(d), 32'h55);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [NL*3-1:0] snap;
    line_pend = '1; line_raw = '1;
    bus_read(4'd9, d);  check("R9 offset9 reads 0", 32'(d), 0);
    bus_read(4'd12, d); check("R9 offset12 reads 0", 32'(d), 0);
    bus_read(4'd15, d); check("R9 offset15 reads 0", 32'(d), 0);
    bus_write(4'd5, 8'd4);
    snap = line_cfg;
    for (int a = 0; a < 16; a++) begin
      if (a != 5 && a != 7) begin
        bus_write(4'(a), 8'hFF);
        check("R9 R10 write gives no response", 32'(rsp_valid), 0);
      end
    end
    check("R9 cfg unchanged", 32'(line_cfg == snap), 1);
    bus_read(4'd5, d); check("R9 select unchanged", 32'(d), 32'h04);
    bus_read(4'd0, d); check("R9 root unchanged", 32'(d), 32'h06);
    line_pend = '0; line_raw = '0;
  endtask

  task automatic t_stall();
    logic [7:0] d;
    bus_write(4'd5, 8'd3);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd5;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h07;
    for (int i = 0; i < 3; i++) begin
      check("R10 rsp held valid", 32'(rsp_valid), 1);
      check("R10 rsp data held", 32'(rsp_rdata), 32'h03);
      check("R10 req blocked", 32'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 rsp consumed", 32'(rsp_valid), 0);
    bus_read(4'd5, d); check("R10 stalled write applied once", 32'(d), 32'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tree();
    t_block();
    t_raw();
    t_sel();
    t_cfg();
    t_clr();
    t_unmapped();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule